// File: doc/BRIEF.md
# Branch-Folding Predecoded Fetch Stage

This block is the instruction fetch stage of a pipelined core. It keeps a small direct-mapped cache of predecoded lines. When a line is filled, the predecoder looks at the instruction and at the word after it. If that following word is a jump, a conditional branch or a call, the control transfer is merged into the line of the instruction before it. The line then carries that instruction, the address to fetch next and a second, alternate address. Fetch moves to the destination in the very next cycle. The transfer instruction itself is never fetched, and no delay slot is exposed.

Folded conditional branches are predicted taken. Downstream logic reports the real outcome on the resolve input in the cycle after the carrying instruction leaves fetch. If the branch turns out not taken, the stage marks the one wrong-path instruction now in its output register as squashed. In that same cycle it looks up the alternate (fall-through) address, so the corrected instruction appears in the next cycle. A folded call flags that a return address must be written back, so that the writer can arbitrate for its register port.

The controller is a two-state machine. In ST_RUN it looks up a line every cycle. The transition RUN_TO_MISS is taken on a lookup miss. ST_MISS holds a fill request. The transition MISS_TO_RUN is taken on fill acknowledge, and it writes the predecoded line. A redirect while in ST_MISS re-aims the fill request without leaving the state (MISS_REAIM).

Top module: `fold_fetch_unit`

## Requirements
- R1: While reset is asserted, fetch_valid and fill_req are low. Reset invalidates every cache line, so after release the first request is a fill of address 0 (RESET_PC), even if that address was cached before.
- R2: On a lookup miss, fill_req rises with fill_addr equal to the missed address. It stays high until fill_ack, and fetch_valid stays low for the whole wait.
- R3: When lines hit, a plain instruction at address A (opcode field bits [15:12] not 4'hA, 4'hB or 4'hC) is followed in the next cycle by the instruction at A+1, with fetch_kind 0.
- R4: A jump (opcode 4'hA, absolute target in bits [7:0]) at A+1 is folded into A. The instruction at A is delivered with fetch_kind 1, the target is delivered in the next cycle when it hits, and address A+1 is never delivered.
- R5: A conditional branch (opcode 4'hB, target in bits [7:0]) at A+1 is folded into A. The instruction at A is delivered with fetch_kind 2 and fetch_alt A+2, and the predicted-taken target follows it.
- R6: A resolve with resolve_taken high, given in the cycle after a branch carrier, leaves fetch_squash low and the taken path continues.
- R7: A resolve with resolve_taken low, given in the cycle after a branch carrier, raises fetch_squash in that cycle. The instruction at fetch_alt is delivered in the following cycle when it hits, so the only bubble is the squashed slot.
- R8: A call (opcode 4'hC) at A+1 is folded into A. The instruction at A is delivered with fetch_kind 3, fetch_link_wr high and fetch_alt A+2 (the return address), and the call target follows it.
- R9: A resolve that does not follow a branch carrier, for example one after a jump carrier, is ignored: fetch_squash stays low and the stream is unchanged.
- R10: A control instruction that is itself the fetch address (a branch target) is delivered as its own carrier. Its kind comes from its opcode, its next address is its target and fetch_alt is its own address plus 1.
- R11: The cache is direct-mapped on the low IDX_W address bits (16 lines by default). A line written by a fill is evicted by a fill of another address with the same index, and a later fetch of the evicted address refills it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_req | output | 1 | Fill request, held during a miss |
| fill_addr | output | 8 | Address of the line being filled |
| fill_ack | input | 1 | Fill words are valid this cycle |
| fill_word0 | input | 16 | Instruction word at fill_addr |
| fill_word1 | input | 16 | Instruction word at fill_addr+1 |
| resolve_valid | input | 1 | Branch outcome is reported this cycle |
| resolve_taken | input | 1 | Reported outcome: 1 taken, 0 not taken |
| fetch_valid | output | 1 | Fetch output holds an instruction |
| fetch_pc | output | 8 | Address of the delivered instruction |
| fetch_insn | output | 16 | Delivered instruction word |
| fetch_kind | output | 2 | Carried transfer: 0 none, 1 jump, 2 branch, 3 call |
| fetch_alt | output | 8 | Fall-through address (branch) or return address (call) |
| fetch_link_wr | output | 1 | Carried call needs a return-address write |
| fetch_squash | output | 1 | Instruction in the fetch output is wrong-path |

## Verification
The assertions assume that the memory side raises fill_ack only while fill_req is high, and that at acknowledge it presents the words at fill_addr and fill_addr+1. They also assume that a resolve for a branch comes in the single cycle after its carrier was delivered. The bench memory model counts its latency against a stable fill address and restarts the count whenever the address changes, so a re-aimed request never takes stale words. The bench raises resolve only in the cycle after a delivered carrier, with one deliberate stray resolve after a jump carrier that the block must ignore.

// File: rtl/fold_pkg.sv
package fold_pkg;

    localparam int PC_W   = 8;
    localparam int INSN_W = 16;
    localparam int OP_W   = 4;

    localparam logic [OP_W-1:0] OP_JUMP   = 4'hA;
    localparam logic [OP_W-1:0] OP_BRANCH = 4'hB;
    localparam logic [OP_W-1:0] OP_CALL   = 4'hC;

    typedef enum logic [1:0] {
        K_PLAIN  = 2'd0,
        K_JUMP   = 2'd1,
        K_BRANCH = 2'd2,
        K_CALL   = 2'd3
    } xfer_e;

    typedef struct packed {
        logic [INSN_W-1:0] insn;
        logic [PC_W-1:0]   next;
        logic [PC_W-1:0]   alt;
        xfer_e             kind;
    } line_t;

    function automatic xfer_e classify(input logic [INSN_W-1:0] w);
        xfer_e k;
        case (w[INSN_W-1 -: OP_W])
            OP_JUMP:   k = K_JUMP;
            OP_BRANCH: k = K_BRANCH;
            OP_CALL:   k = K_CALL;
            default:   k = K_PLAIN;
        endcase
        return k;
    endfunction

    function automatic logic [PC_W-1:0] target_of(input logic [INSN_W-1:0] w);
        return w[PC_W-1:0];
    endfunction

endpackage

// File: rtl/fold_predecode.sv
module fold_predecode
    import fold_pkg::*;
(
    input  logic [PC_W-1:0]   base_addr,
    input  logic [INSN_W-1:0] word_here,
    input  logic [INSN_W-1:0] word_after,
    output line_t             line
);

    xfer_e kind_here;
    xfer_e kind_after;

    assign kind_here  = classify(word_here);
    assign kind_after = classify(word_after);

    always_comb begin
        line.insn = word_here;
        if (kind_here != K_PLAIN) begin
            // R10: control word reached directly carries itself
            line.kind = kind_here;
            line.next = target_of(word_here);
            line.alt  = base_addr + PC_W'(1);
        end else if (kind_after != K_PLAIN) begin
            // R4 R5 R8: following transfer folded into this word
            line.kind = kind_after;
            line.next = target_of(word_after);
            line.alt  = base_addr + PC_W'(2);
        end else begin
            line.kind = K_PLAIN;
            line.next = base_addr + PC_W'(1);
            line.alt  = base_addr + PC_W'(1);
        end
    end

endmodule

// File: rtl/fold_line_store.sv
module fold_line_store
    import fold_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_addr,
    input  line_t           wr_line,
    input  logic [PC_W-1:0] rd_addr,
    output logic            rd_hit,
    output line_t           rd_line
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W;

    logic [DEPTH-1:0] vld;
    logic [TAG_W-1:0] tags  [DEPTH];
    line_t            lines [DEPTH];

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_idx = wr_addr[IDX_W-1:0];
    assign rd_idx = rd_addr[IDX_W-1:0];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        line_t            l_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                t_q <= wr_addr[PC_W-1:IDX_W];
                l_q <= wr_line;
            end
        end

        assign vld[e]   = v_q;
        assign tags[e]  = t_q;
        assign lines[e] = l_q;
    end

    // R11: direct-mapped lookup on low address bits, tag on the rest
    assign rd_hit  = vld[rd_idx] && (tags[rd_idx] == rd_addr[PC_W-1:IDX_W]);
    assign rd_line = lines[rd_idx];

    // R11: a line just written is found by a read of the same address
    p_write_then_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_addr != $past(wr_addr)) || rd_hit);

endmodule

// File: rtl/fold_fetch_ctrl.sv
module fold_fetch_ctrl
    import fold_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] look_addr,
    input  logic            look_hit,
    input  line_t           look_line,
    output logic            fill_req,
    output logic [PC_W-1:0] fill_addr,
    input  logic            fill_ack,
    output logic            fill_wr,
    input  logic            resolve_valid,
    input  logic            resolve_taken,
    output logic            out_valid,
    output logic [PC_W-1:0] out_pc,
    output line_t           out_line,
    output logic            squash
);

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_MISS = 1'b1
    } fstate_e;

    fstate_e         state_q;
    fstate_e         state_d;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic            load_out;
    logic            pend_q;
    logic [PC_W-1:0] pend_alt_q;
    logic            redirect;

    // R7 R9: only a resolve that follows a branch carrier can redirect
    assign redirect  = pend_q && resolve_valid && !resolve_taken;
    assign squash    = redirect;
    assign look_addr = redirect ? pend_alt_q : pc_q;
    assign fill_req  = (state_q == ST_MISS);
    assign fill_addr = pc_q;

    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        load_out = 1'b0;
        fill_wr  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (look_hit) begin
                    load_out = 1'b1;
                    pc_d     = look_line.next;
                end else begin
                    pc_d    = look_addr;
                    state_d = ST_MISS;
                end
            end
            ST_MISS: begin
                if (fill_ack) begin
                    fill_wr = 1'b1;
                    state_d = ST_RUN;
                end
                if (redirect) begin
                    pc_d = pend_alt_q;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= RESET_PC;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_pc     <= '0;
            out_line   <= '0;
            pend_q     <= 1'b0;
            pend_alt_q <= '0;
        end else begin
            out_valid  <= load_out;
            if (load_out) begin
                out_pc   <= look_addr;
                out_line <= look_line;
            end
            pend_q     <= out_valid && (out_line.kind == K_BRANCH) && !redirect;
            pend_alt_q <= out_line.alt;
        end
    end

    // R2: a pending fill is held until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !fill_ack |=> fill_req);

    // R2: nothing is delivered while a fill is outstanding
    p_no_fetch_in_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !out_valid);

    // R4: a surviving delivery is followed by its recorded next address
    p_next_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !squash |=> !out_valid || (out_pc == $past(out_line.next)));

    // R7: after a squash the next delivery is the carrier's alternate
    p_alt_after_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !out_valid || (out_pc == $past(out_line.alt, 2)));

endmodule

// File: rtl/fold_fetch_unit.sv
module fold_fetch_unit
    import fold_pkg::*;
#(
    parameter int              IDX_W    = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fill_req,
    output logic [PC_W-1:0]   fill_addr,
    input  logic              fill_ack,
    input  logic [INSN_W-1:0] fill_word0,
    input  logic [INSN_W-1:0] fill_word1,
    input  logic              resolve_valid,
    input  logic              resolve_taken,
    output logic              fetch_valid,
    output logic [PC_W-1:0]   fetch_pc,
    output logic [INSN_W-1:0] fetch_insn,
    output logic [1:0]        fetch_kind,
    output logic [PC_W-1:0]   fetch_alt,
    output logic              fetch_link_wr,
    output logic              fetch_squash
);

    line_t           fill_line;
    line_t           look_line;
    line_t           out_line;
    logic [PC_W-1:0] look_addr;
    logic            look_hit;
    logic            fill_wr;

    fold_predecode u_predecode (
        .base_addr  (fill_addr),
        .word_here  (fill_word0),
        .word_after (fill_word1),
        .line       (fill_line)
    );

    fold_line_store #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_wr),
        .wr_addr (fill_addr),
        .wr_line (fill_line),
        .rd_addr (look_addr),
        .rd_hit  (look_hit),
        .rd_line (look_line)
    );

    fold_fetch_ctrl #(.RESET_PC(RESET_PC)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .look_addr     (look_addr),
        .look_hit      (look_hit),
        .look_line     (look_line),
        .fill_req      (fill_req),
        .fill_addr     (fill_addr),
        .fill_ack      (fill_ack),
        .fill_wr       (fill_wr),
        .resolve_valid (resolve_valid),
        .resolve_taken (resolve_taken),
        .out_valid     (fetch_valid),
        .out_pc        (fetch_pc),
        .out_line      (out_line),
        .squash        (fetch_squash)
    );

    assign fetch_insn    = out_line.insn;
    assign fetch_kind    = out_line.kind;
    assign fetch_alt     = out_line.alt;
    // R8: carried call asks for a return-address write
    assign fetch_link_wr = fetch_valid && (out_line.kind == K_CALL);

    // R9: a squash only ever follows a delivered branch carrier
    p_squash_after_branch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_squash |-> $past(fetch_valid) && ($past(fetch_kind) == 2'd2));

endmodule

// File: tb/tb_fold_fetch_unit.sv
module tb_fold_fetch_unit;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam int WD_LIMIT   = 20000;
    localparam int NSTEP      = 22;

    // entry: {pc[8], kind[2], alt[8], drive, taken, gap[2]}
    localparam logic [21:0] TBL [NSTEP] = '{
        {8'd0,  2'd0, 8'd0,  1'b0, 1'b0, 2'd0},
        {8'd1,  2'd1, 8'd0,  1'b1, 1'b0, 2'd0},
        {8'd8,  2'd2, 8'd10, 1'b1, 1'b1, 2'd0},
        {8'd20, 2'd3, 8'd22, 1'b0, 1'b0, 2'd0},
        {8'd40, 2'd2, 8'd42, 1'b1, 1'b1, 2'd0},
        {8'd9,  2'd2, 8'd10, 1'b1, 1'b0, 2'd0},
        {8'd10, 2'd0, 8'd0,  1'b0, 1'b0, 2'd0},
        {8'd11, 2'd0, 8'd0,  1'b0, 1'b0, 2'd0},
        {8'd12, 2'd1, 8'd0,  1'b0, 1'b0, 2'd0},
        {8'd0,  2'd0, 8'd0,  1'b0, 1'b0, 2'd1},
        {8'd1,  2'd1, 8'd0,  1'b0, 1'b0, 2'd1},
        {8'd8,  2'd2, 8'd10, 1'b1, 1'b0, 2'd0},
        {8'd10, 2'd0, 8'd0,  1'b0, 1'b0, 2'd2},
        {8'd11, 2'd0, 8'd0,  1'b0, 1'b0, 2'd1},
        {8'd12, 2'd1, 8'd0,  1'b0, 1'b0, 2'd1},
        {8'd0,  2'd0, 8'd0,  1'b0, 1'b0, 2'd1},
        {8'd1,  2'd1, 8'd0,  1'b0, 1'b0, 2'd1},
        {8'd8,  2'd2, 8'd10, 1'b1, 1'b1, 2'd1},
        {8'd20, 2'd3, 8'd22, 1'b0, 1'b0, 2'd1},
        {8'd40, 2'd2, 8'd42, 1'b1, 1'b0, 2'd0},
        {8'd42, 2'd0, 8'd0,  1'b0, 1'b0, 2'd0},
        {8'd43, 2'd0, 8'd0,  1'b0, 1'b0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fill_req;
    logic [7:0]  fill_addr;
    logic        fill_ack;
    logic [15:0] fill_word0;
    logic [15:0] fill_word1;
    logic        resolve_valid;
    logic        resolve_taken;
    logic        fetch_valid;
    logic [7:0]  fetch_pc;
    logic [15:0] fetch_insn;
    logic [1:0]  fetch_kind;
    logic [7:0]  fetch_alt;
    logic        fetch_link_wr;
    logic        fetch_squash;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    int ack_cnt [256];
    logic [7:0] lat_addr = 8'hFF;
    int         lat_cnt  = 0;

    logic [7:0] s_pc;
    logic [1:0] s_kind;
    logic [7:0] s_alt;
    logic       s_link;
    logic [15:0] s_insn;
    int         s_cyc;

    fold_fetch_unit dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fill_req      (fill_req),
        .fill_addr     (fill_addr),
        .fill_ack      (fill_ack),
        .fill_word0    (fill_word0),
        .fill_word1    (fill_word1),
        .resolve_valid (resolve_valid),
        .resolve_taken (resolve_taken),
        .fetch_valid   (fetch_valid),
        .fetch_pc      (fetch_pc),
        .fetch_insn    (fetch_insn),
        .fetch_kind    (fetch_kind),
        .fetch_alt     (fetch_alt),
        .fetch_link_wr (fetch_link_wr),
        .fetch_squash  (fetch_squash)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // program: jump at 2 and 13, branch at 9 and 41, call at 21
    function automatic logic [15:0] mem_word(input logic [7:0] a);
        case (a)
            8'd2:    return 16'hA008;
            8'd9:    return 16'hB014;
            8'd13:   return 16'hA000;
            8'd21:   return 16'hC028;
            8'd41:   return 16'hB009;
            default: return {8'h10, a};
        endcase
    endfunction

    assign fill_word0 = mem_word(fill_addr);
    assign fill_word1 = mem_word(fill_addr + 8'd1);
    assign fill_ack   = fill_req && (fill_addr == lat_addr) && (lat_cnt >= MEM_LAT);

    always @(posedge clk) begin
        if (fill_req && (fill_addr == lat_addr) && !fill_ack) begin
            lat_cnt <= lat_cnt + 1;
        end else begin
            lat_cnt  <= 0;
            lat_addr <= fill_addr;
        end
        if (fill_ack) ack_cnt[fill_addr] <= ack_cnt[fill_addr] + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            checks   = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog: run hung, act=%0d exp<%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic capture();
        s_pc   = fetch_pc;
        s_kind = fetch_kind;
        s_alt  = fetch_alt;
        s_link = fetch_link_wr;
        s_insn = fetch_insn;
        s_cyc  = cyc;
    endtask

    task automatic wait_item();
        do @(negedge clk); while (!(fetch_valid && !fetch_squash));
        capture();
    endtask

    initial begin
        bit   pend_item;
        bit   late;
        bit   r2_ok;
        int   prev_cyc;
        rst_n         = 1'b0;
        resolve_valid = 1'b0;
        resolve_taken = 1'b0;
        pend_item     = 1'b0;
        late          = 1'b0;
        prev_cyc      = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet in reset
        chk(!fetch_valid && !fill_req, "R1 reset outputs", {fetch_valid, fill_req}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        while (!fill_req) @(negedge clk);
        // R1: first fill at reset address
        chk(fill_addr == 8'd0, "R1 first fill address", fill_addr, 0);
        // R2: request held, no delivery until acknowledge
        r2_ok = 1'b1;
        while (!fill_ack) begin
            if (!fill_req || fill_addr != 8'd0 || fetch_valid) r2_ok = 1'b0;
            @(negedge clk);
        end
        chk(r2_ok, "R2 miss hold", r2_ok, 1);

        for (int i = 0; i < NSTEP; i++) begin
            logic [7:0] e_pc;
            logic [1:0] e_kind;
            logic [7:0] e_alt;
            logic       e_drive;
            logic       e_taken;
            logic [1:0] e_gap;
            bit         exp_sq;
            string      tag;
            {e_pc, e_kind, e_alt, e_drive, e_taken, e_gap} = TBL[i];
            if (!pend_item) begin
                wait_item();
                late = 1'b0;
            end
            pend_item = 1'b0;
            case (e_kind)
                2'd1:    tag = "R4 jump fold";
                2'd2:    tag = "R5 branch fold";
                2'd3:    tag = "R8 call fold";
                default: tag = "R3 plain sequence";
            endcase
            if (e_kind != 2'd0 && e_alt == e_pc + 8'd1) tag = "R10 direct carrier";
            chk(s_pc == e_pc, tag, s_pc, e_pc);
            chk(s_insn == mem_word(e_pc), tag, s_insn, mem_word(e_pc));
            chk(s_kind == e_kind, tag, s_kind, e_kind);
            if (e_kind >= 2'd2) chk(s_alt == e_alt, tag, s_alt, e_alt);
            chk(s_link == (e_kind == 2'd3), "R8 link write flag", s_link, e_kind == 2'd3);
            if (e_gap != 2'd0)
                chk((s_cyc - prev_cyc) == int'(e_gap),
                    (e_gap == 2'd2) ? "R7 one-slot bubble" : "R3 back-to-back hit",
                    s_cyc - prev_cyc, e_gap);
            prev_cyc = s_cyc;
            if (e_drive) begin
                if (!late) begin
                    @(posedge clk);
                    #1;
                end
                resolve_valid = 1'b1;
                resolve_taken = e_taken;
                @(negedge clk);
                exp_sq = (e_kind == 2'd2) && !e_taken;
                chk(fetch_squash == exp_sq,
                    (e_kind != 2'd2) ? "R9 stray resolve" : (e_taken ? "R6 taken" : "R7 not taken"),
                    fetch_squash, exp_sq);
                if (fetch_valid && !fetch_squash) begin
                    pend_item = 1'b1;
                    capture();
                end
                @(posedge clk);
                #1;
                resolve_valid = 1'b0;
                resolve_taken = 1'b0;
                late = pend_item;
            end
        end

        // R11: conflicting index 8 lines evicted and refilled
        chk(ack_cnt[8] == 2, "R11 refill after eviction", ack_cnt[8], 2);
        chk(ack_cnt[40] == 2, "R11 refill after eviction", ack_cnt[40], 2);

        // R1: reset mid-run clears the cache
        @(posedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        chk(!fetch_valid && !fill_req, "R1 reset outputs mid-run", {fetch_valid, fill_req}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(fill_req && fill_addr == 8'd0, "R1 cache invalidated by reset",
            {fill_req, fill_addr}, {1'b1, 8'd0});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule